// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler/Postscaler Divider

This block is the watchdog of a small microcontroller. An 8-bit base counter advances on a free-running watchdog tick. That tick comes from a slow oscillator of its own, so the counter keeps counting while the processor sleeps and its main clock is gated. Inside the block the tick is modelled as a one-cycle enable on the always-running block clock. When the watchdog runs out, it asks the device to reset if the device is awake, or to wake up if it is asleep. A status flag records that a time-out happened.

One 8-stage binary divider is shared with a general-purpose timer. A single assignment bit decides who owns it:
- Given to the watchdog, the divider counts base-counter overflows and acts as a postscaler, so a time-out happens only every 2^sel overflows.
- Given to the timer, it divides the timer's count-source pulses by 2^(sel+1) and feeds the result to the timer. Every overflow of the watchdog is then a time-out.

Software keeps the watchdog from expiring with a clear strobe. A sleep-entry strobe restarts it in the same way.

Top module: `wdog_postdiv`

## Requirements
- R1: The base counter advances once per cycle with `wdt_tick_i` high. With the divider owned by the watchdog and `div_sel_i` = 0, the 256th tick after a clear is a time-out.
- R2: A time-out with `asleep_i` low gives a one-cycle `reset_req_o` pulse in the cycle after the time-out tick, and no `wake_req_o`.
- R3: The counter keeps counting while `asleep_i` is high. A time-out then gives a one-cycle `wake_req_o` pulse instead of a reset request.
- R4: `to_flag_o` is 1 after power-up reset and after a `clrwdt_i` strobe. It becomes 0 in the cycle after a time-out. The sleep strobe leaves it unchanged.
- R5: While `wdt_en_i` is 0 the base counter is held at zero, and no reset or wake request is ever raised.
- R6: With `div_to_wdt_i` = 1 (divider owned by the watchdog), a time-out happens once every 2^`div_sel_i` overflows: 1:1 for 0 up to 1:128 for 7.
- R7: With `div_to_wdt_i` = 0 (divider owned by the timer), `tmr_inc_o` pulses once per 2^(`div_sel_i`+1) `tmr_src_i` pulses, one cycle after the pulse that completes the count. Every overflow of the watchdog is then a time-out.
- R8: With `div_to_wdt_i` = 1, `tmr_inc_o` repeats every `tmr_src_i` pulse undivided, one cycle later.
- R9: `clrwdt_i` and `sleep_cmd_i` both zero the base counter, and they take priority over a tick in the same cycle. They also zero the divider if it is owned by the watchdog. If it is owned by the timer, its count is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Active-low power-up reset |
| wdt_tick_i | input | 1 | One-cycle enable from the watchdog oscillator |
| tmr_src_i | input | 1 | One-cycle count-source pulse for the general-purpose timer |
| clrwdt_i | input | 1 | Watchdog clear strobe |
| sleep_cmd_i | input | 1 | Sleep-entry strobe |
| asleep_i | input | 1 | Device is in sleep mode |
| wdt_en_i | input | 1 | Permanent watchdog enable (configuration) |
| div_to_wdt_i | input | 1 | Divider owner: 1 = watchdog postscaler, 0 = timer prescaler |
| div_sel_i | input | 3 | Divider tap select |
| reset_req_o | output | 1 | One-cycle device reset request |
| wake_req_o | output | 1 | One-cycle wake-up request |
| to_flag_o | output | 1 | Time-out status, 0 after a time-out |
| tmr_inc_o | output | 1 | Divided count enable to the general-purpose timer |

## Verification
A wrong base count shows as a request arriving one or more ticks away from the 256-tick boundary after a clear. A divider count that is wrongly cleared or kept shifts the phase of `tmr_inc_o` at the next source pulse in timer mode, or it moves the next time-out by whole overflows in watchdog mode. A bench model built from these rules predicts all four outputs every cycle, so any such slip is reported in the first cycle the outputs disagree. Directed runs measure the exact tick counts to a time-out at the boundary taps.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        OWNER_TIMER = 1'b0,
        OWNER_WDOG  = 1'b1
    } div_owner_e;

    typedef struct packed {
        logic rst_req;
        logic wake_req;
        logic flag;
    } evt_state_t;

endpackage

// File: rtl/wdog_basecnt.sv
module wdog_basecnt #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    input  logic clr_i,
    output logic ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = 1'b0;
        if (!en_i || clr_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            ovf_o    = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a clear strobe leaves the counter at zero
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.cnt == '0));

    // R5: disabled watchdog keeps its counter at zero
    a_r5_disabled_held: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.cnt == '0));

    // R1: without a tick and without clear the count does not move
    a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !tick_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/wdog_shared_div.sv
module wdog_shared_div
    import wdog_pkg::*;
#(
    parameter int TAPS  = 8,
    parameter int SEL_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovf_i,
    input  logic             src_i,
    input  logic             clr_i,
    input  div_owner_e       owner_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             timeout_o,
    output logic             tmr_inc_o
);

    typedef struct packed {
        logic [TAPS-1:0] div;
        logic            inc;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [TAPS-1:0] post_hit;
    logic [TAPS-1:0] pre_hit;

    // post_hit[k]: the low k stages are all ones, so the next overflow
    // completes a 2^k group. pre_hit[k]: the low k+1 stages are all ones.
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_first
            assign post_hit[k] = 1'b1;
        end else begin : g_rest
            assign post_hit[k] = &st_q.div[k-1:0];
        end
        assign pre_hit[k] = &st_q.div[k:0];
    end

    always_comb begin
        st_d      = st_q;
        timeout_o = 1'b0;
        if (owner_i == OWNER_WDOG) begin
            timeout_o = ovf_i & post_hit[sel_i];
            st_d.inc  = src_i;
            if (clr_i)      st_d.div = '0;
            else if (ovf_i) st_d.div = st_q.div + 1'b1;
        end else begin
            timeout_o = ovf_i;
            st_d.inc  = src_i & pre_hit[sel_i];
            if (src_i)      st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_inc_o = st_q.inc;

    // R9: clearing while owned by the watchdog empties the divider
    a_r9_div_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && owner_i == OWNER_WDOG) |=> (st_q.div == '0));

    // R9: clearing while owned by the timer keeps the divider count
    a_r9_div_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && owner_i == OWNER_TIMER && !src_i) |=> $stable(st_q.div));

    // R8: owned by the watchdog, the timer sees the raw source one cycle later
    a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_i == OWNER_WDOG) |=> (tmr_inc_o == $past(src_i)));

endmodule

// File: rtl/wdog_outreg.sv
module wdog_outreg
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic timeout_i,
    input  logic asleep_i,
    input  logic clrwdt_i,
    output logic reset_req_o,
    output logic wake_req_o,
    output logic to_flag_o
);

    evt_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rst_req  = timeout_i & ~asleep_i;
        st_d.wake_req = timeout_i & asleep_i;
        if (clrwdt_i)       st_d.flag = 1'b1;
        else if (timeout_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rst_req: 1'b0, wake_req: 1'b0, flag: 1'b1};
        else        st_q <= st_d;
    end

    assign reset_req_o = st_q.rst_req;
    assign wake_req_o  = st_q.wake_req;
    assign to_flag_o   = st_q.flag;

    // R2/R3: reset and wake requests never coincide
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reset_req_o, wake_req_o}));

    // R2: a reset request lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> !reset_req_o);

    // R3: a wake request lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |=> !wake_req_o);

    // R4: any request comes with the flag already low
    a_r4_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req_o || wake_req_o) |-> !to_flag_o);

    // R4: a clear strobe raises the flag
    a_r4_clear_sets: assert property (@(posedge clk) disable iff (!rst_n)
        clrwdt_i |=> to_flag_o);

endmodule

// File: rtl/wdog_postdiv.sv
module wdog_postdiv
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TAPS  = 8,
    parameter int SEL_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_tick_i,
    input  logic             tmr_src_i,
    input  logic             clrwdt_i,
    input  logic             sleep_cmd_i,
    input  logic             asleep_i,
    input  logic             wdt_en_i,
    input  logic             div_to_wdt_i,
    input  logic [SEL_W-1:0] div_sel_i,
    output logic             reset_req_o,
    output logic             wake_req_o,
    output logic             to_flag_o,
    output logic             tmr_inc_o
);

    logic       clr_any;
    logic       ovf;
    logic       timeout;
    div_owner_e owner;

    assign clr_any = clrwdt_i | sleep_cmd_i;
    assign owner   = div_to_wdt_i ? OWNER_WDOG : OWNER_TIMER;

    wdog_basecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (wdt_tick_i),
        .en_i   (wdt_en_i),
        .clr_i  (clr_any),
        .ovf_o  (ovf)
    );

    wdog_shared_div #(.TAPS(TAPS), .SEL_W(SEL_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_i     (ovf),
        .src_i     (tmr_src_i),
        .clr_i     (clr_any),
        .owner_i   (owner),
        .sel_i     (div_sel_i),
        .timeout_o (timeout),
        .tmr_inc_o (tmr_inc_o)
    );

    wdog_outreg u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .timeout_i   (timeout),
        .asleep_i    (asleep_i),
        .clrwdt_i    (clrwdt_i),
        .reset_req_o (reset_req_o),
        .wake_req_o  (wake_req_o),
        .to_flag_o   (to_flag_o)
    );

    // R5: a disabled watchdog raises no request in the following cycle
    a_r5_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en_i |=> !(reset_req_o || wake_req_o));

    // R9: a clear strobe suppresses any request in the following cycle
    a_r9_clear_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> !(reset_req_o || wake_req_o));

endmodule

// File: tb/wdog_postdiv_tb.sv
module wdog_postdiv_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_tick_i = 1'b0, tmr_src_i = 1'b0, clrwdt_i = 1'b0;
    logic       sleep_cmd_i = 1'b0, asleep_i = 1'b0, wdt_en_i = 1'b1;
    logic       div_to_wdt_i = 1'b1;
    logic [2:0] div_sel_i = 3'd0;
    logic       reset_req_o, wake_req_o, to_flag_o, tmr_inc_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    int m_cnt = 0, m_div = 0;
    bit m_flag = 1'b1, e_rst = 1'b0, e_wake = 1'b0, e_inc = 1'b0;

    always #2 clk = ~clk;

    wdog_postdiv u_dut (
        .clk(clk), .rst_n(rst_n), .wdt_tick_i(wdt_tick_i), .tmr_src_i(tmr_src_i),
        .clrwdt_i(clrwdt_i), .sleep_cmd_i(sleep_cmd_i), .asleep_i(asleep_i),
        .wdt_en_i(wdt_en_i), .div_to_wdt_i(div_to_wdt_i), .div_sel_i(div_sel_i),
        .reset_req_o(reset_req_o), .wake_req_o(wake_req_o),
        .to_flag_o(to_flag_o), .tmr_inc_o(tmr_inc_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model step from the requirements, then one clock, then compare.
    task automatic step(input bit tk, input bit src, input bit cw, input bit sl);
        bit clr, ovf, to;
        int mask;
        wdt_tick_i = tk; tmr_src_i = src; clrwdt_i = cw; sleep_cmd_i = sl;
        clr = cw | sl; ovf = 1'b0; to = 1'b0;
        if (!wdt_en_i || clr) m_cnt = 0;
        else if (tk) begin ovf = (m_cnt == 255); m_cnt = (m_cnt + 1) % 256; end
        if (div_to_wdt_i) begin
            mask  = (1 << div_sel_i) - 1;
            to    = ovf && ((m_div & mask) == mask);
            e_inc = src;
            if (clr) m_div = 0;
            else if (ovf) m_div = (m_div + 1) % 256;
        end else begin
            mask  = (2 << div_sel_i) - 1;
            to    = ovf;
            e_inc = src && ((m_div & mask) == mask);
            if (src) m_div = (m_div + 1) % 256;
        end
        e_rst  = to && !asleep_i;
        e_wake = to && asleep_i;
        if (cw) m_flag = 1'b1;
        else if (to) m_flag = 1'b0;
        @(negedge clk);
        check(reset_req_o == e_rst,  "R2 reset_req", reset_req_o, e_rst);
        check(wake_req_o  == e_wake, "R3 wake_req",  wake_req_o,  e_wake);
        check(to_flag_o   == m_flag, "R4 to_flag",   to_flag_o,   m_flag);
        check(tmr_inc_o   == e_inc,  div_to_wdt_i ? "R8 tmr_inc" : "R7 tmr_inc",
              tmr_inc_o, e_inc);
    endtask

    // Tick every cycle until a request appears; return the tick count.
    task automatic ticks_to_req(input int limit, output int n);
        n = 0;
        do begin
            step(1'b1, 1'b0, 1'b0, 1'b0);
            n++;
        end while (!reset_req_o && !wake_req_o && n < limit);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, incs, seed;
        seed = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        check(reset_req_o == 0 && wake_req_o == 0, "R2 reset idle", reset_req_o, 0);
        check(to_flag_o == 1, "R4 flag after power-up", to_flag_o, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: sel 0, awake, exactly 256 ticks
        step(1'b0, 1'b0, 1'b1, 1'b0);
        ticks_to_req(1000, n);
        check(n == 256 && reset_req_o, "R1 ticks to time-out", n, 256);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check(to_flag_o == 0, "R4 flag after time-out", to_flag_o, 0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check(to_flag_o == 1, "R4 flag after clear", to_flag_o, 1);

        // R3: asleep, time-out wakes instead of resetting
        asleep_i = 1'b1;
        ticks_to_req(1000, n);
        check(n == 256 && wake_req_o && !reset_req_o, "R3 wake on time-out", n, 256);
        asleep_i = 1'b0;

        // R6: boundary taps of the postscaler
        div_sel_i = 3'd3;
        step(1'b0, 1'b0, 1'b1, 1'b0);
        ticks_to_req(5000, n);
        check(n == 2048, "R6 postscale 1:8", n, 2048);
        div_sel_i = 3'd7;
        step(1'b0, 1'b0, 1'b0, 1'b1);
        ticks_to_req(40000, n);
        check(n == 32768, "R6 postscale 1:128", n, 32768);

        // R9: clear wins over a same-cycle tick; sleep strobe restarts too
        div_sel_i = 3'd0;
        repeat (200) step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        ticks_to_req(1000, n);
        check(n == 256, "R9 clear over tick", n, 256);
        repeat (100) step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        ticks_to_req(1000, n);
        check(n == 256, "R9 sleep strobe restart", n, 256);

        // R5: disabled, no request over many ticks
        wdt_en_i = 1'b0;
        ticks_to_req(3000, n);
        check(n == 3000, "R5 disabled never times out", n, 3000);
        wdt_en_i = 1'b1;

        // R7: timer owns the divider, sel 1 gives 1:4; watchdog 1:1
        div_to_wdt_i = 1'b0; div_sel_i = 3'd1;
        step(1'b0, 1'b0, 1'b1, 1'b0);
        incs = 0;
        for (int i = 0; i < 64; i++) begin
            step(1'b0, 1'b1, 1'b0, 1'b0);
            if (tmr_inc_o) incs++;
        end
        check(incs == 16, "R7 prescale 1:4", incs, 16);
        div_sel_i = 3'd7;
        ticks_to_req(1000, n);
        check(n <= 256 && reset_req_o, "R7 watchdog undivided", n, 256);
        // R9: clears in timer mode keep the divider phase
        div_sel_i = 3'd0;
        step(1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check(tmr_inc_o == e_inc, "R9 divider kept in timer mode", tmr_inc_o, e_inc);

        // R8: watchdog owns the divider, timer gets every source pulse
        div_to_wdt_i = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check(tmr_inc_o == 1, "R8 passthrough", tmr_inc_o, 1);

        // Random mix against the model
        for (int i = 0; i < 40000; i++) begin
            if ($urandom_range(0, 499) == 0) asleep_i = ~asleep_i;
            if ($urandom_range(0, 999) == 0) wdt_en_i = ~wdt_en_i;
            if ($urandom_range(0, 799) == 0) div_to_wdt_i = ~div_to_wdt_i;
            if ($urandom_range(0, 599) == 0) div_sel_i = 3'($urandom_range(0, 3));
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 1999) == 0, $urandom_range(0, 2999) == 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule